// File: doc/BRIEF.md
# Field-Bus Slave Output Reset Sequencer

This block brings the output stage of a sensor/actuator field-bus slave into a known state whenever a reset occurs, and holds it there until initialization has run its course. Three reset sources feed it: a digital power-on reset pulse from the analog supply monitor, a software reset request raised by the command decoder (slave reset or broadcast reset), and an external reset input. Every reset source is synchronized to the clock. While any synchronized reset is active, both output registers are preset to all ones. Both pin drivers are disabled. A flag that locks out data exchange is raised, and an initialization timer is armed.

The length of the timer depends on the kind of reset. A power-on reset gets the long window (30 ms). A software or external reset gets the short window (2 ms). Both windows are counted in clock cycles that are derived from the clock frequency parameter. When a software or external reset ends, the data strobe and the parameter strobe pulse together, so that downstream logic picks up the preset values. A power-on reset ends silently.

Once initialization is over, a parameter write loads the parameter register, releases the data-exchange lock and enables the drivers. Data exchange requests only take effect after that. A reset that arrives while initialization is still running restarts the timer with the newest reset kind.

Top module: `slave_reset_seq`

## Requirements
- R1: In the cycle after any synchronized reset is active, data_out and par_out both read 4'hF.
- R2: In the cycle after any synchronized reset is active, data_oe and par_oe are both low.
- R3: When a software or external reset ends, data_stb and par_stb are high together for exactly one cycle, in the cycle after the first clock that sees all synchronized resets low.
- R4: A reset whose last active cycle was a power-on reset produces no data_stb and no par_stb.
- R5: In the cycle after any synchronized reset is active, dx_lock and init_busy are both high.
- R6: A data exchange request made while dx_lock is high leaves data_out unchanged and gives no data_stb. This also holds when a parameter write arrives in the same cycle, because the lock is judged on its value before that write.
- R7: Let P be the cycles a reset input is held and L the window length in cycles, with L = CLK_HZ/1000 × 2 for software/external and CLK_HZ/1000 × 30 for power-on. Starting from an idle block, init_busy is high for exactly P + L − 1 cycles, and it stays high for L − 1 cycles counted from the cycle in which the release strobe is seen.
- R8: Requests made while init_busy is high change neither par_out, data_out, dx_lock nor any strobe.
- R9: A parameter write with init_busy low loads par_out from par_wdata in the next cycle. In that same cycle it pulses par_stb alone, clears dx_lock and sets both output enables.
- R10: A data exchange request with init_busy and dx_lock low loads data_out from dx_wdata in the next cycle. In that same cycle it pulses data_stb alone and sets both output enables.
- R11: A reset arriving during initialization restarts the timer with the window of the new reset kind. The release strobes follow the kind of the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, treated as a power-on reset |
| por_in | input | 1 | Power-on reset pulse from the supply monitor, active high |
| sw_rst_req | input | 1 | Software reset request from the command decoder, active high |
| ext_rst_req | input | 1 | External reset input, active high |
| dx_req | input | 1 | Data exchange request |
| dx_wdata | input | DW | Data for the data output register |
| pw_req | input | 1 | Parameter write request |
| pw_wdata | input | DW | Data for the parameter output register |
| data_out | output | DW | Data output register |
| data_oe | output | 1 | Data pin driver enable |
| par_out | output | DW | Parameter output register |
| par_oe | output | 1 | Parameter pin driver enable |
| data_stb | output | 1 | Data strobe, one-cycle pulse |
| par_stb | output | 1 | Parameter strobe, one-cycle pulse |
| init_busy | output | 1 | Initialization in progress |
| dx_lock | output | 1 | Data exchange lock flag |

## Verification
Each reset kind is applied with a different pulse width, and the busy length is measured. This separates the short window from the long one and shows whether the pulse width adds to the window as expected. Overlapping resets check that the newest kind, and not the first, sets both the timer and whether strobes appear. Parameter and data values are swept over all sixteen codes, which exposes stuck or swapped bits in the register loads. Data exchange requests are made before any parameter write, in the same cycle as a parameter write, and during initialization, and each case shows whether the lock and busy gating hold.

// File: rtl/slv_rst_pkg.sv
package slv_rst_pkg;

  typedef enum logic [1:0] {
    RK_POR = 2'd0,
    RK_EXT = 2'd1,
    RK_SW  = 2'd2
  } rst_kind_e;

  // src[0] power-on, src[1] external, src[2] software; power-on wins
  function automatic rst_kind_e pick_kind(input logic [2:0] src);
    rst_kind_e k;
    if (src[0])      k = RK_POR;
    else if (src[1]) k = RK_EXT;
    else             k = RK_SW;
    return k;
  endfunction

endpackage

// File: rtl/slv_rst_sync.sv
module slv_rst_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
      end
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/slv_rst_timer.sv
module slv_rst_timer
  import slv_rst_pkg::*;
#(
  parameter int SHORT_CYC = 8,
  parameter int LONG_CYC  = 120,
  parameter int CNT_W     = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_any,
  input  rst_kind_e kind_in,
  output logic      busy,
  output logic      rel_stb
);

  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             seen_q;
  rst_kind_e        kind_q, kind_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    kind_d = kind_q;
    cnt_en = rst_any | busy_q;
    if (rst_any) begin
      kind_d = kind_in;
      busy_d = 1'b1;
      cnt_d  = (kind_in == RK_POR) ? LONG_LAST : SHORT_LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LONG_LAST;
      busy_q <= 1'b1;
      kind_q <= RK_POR;
      seen_q <= 1'b0;
    end else begin
      seen_q <= rst_any;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
        kind_q <= kind_d;
      end
    end
  end

  assign busy    = busy_q;
  assign rel_stb = seen_q & ~rst_any & (kind_q != RK_POR);

endmodule

// File: rtl/slv_rst_outs.sv
module slv_rst_outs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_any,
  input  logic          busy,
  input  logic          rel_stb,
  input  logic          dx_req,
  input  logic [DW-1:0] dx_wdata,
  input  logic          pw_req,
  input  logic [DW-1:0] pw_wdata,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] par_out,
  output logic          oe,
  output logic          lock,
  output logic          data_stb,
  output logic          par_stb
);

  logic [DW-1:0] data_q, data_d, par_q, par_d;
  logic          oe_q, oe_d, lock_q, lock_d;
  logic          dstb_q, dstb_d, pstb_q, pstb_d;
  logic          accept, pw_ok, dx_ok;

  always_comb begin
    accept = ~rst_any & ~busy;
    pw_ok  = accept & pw_req;
    dx_ok  = accept & dx_req & ~lock_q;
    data_d = data_q;
    par_d  = par_q;
    oe_d   = oe_q;
    lock_d = lock_q;
    if (rst_any) begin
      data_d = '1;
      par_d  = '1;
      oe_d   = 1'b0;
      lock_d = 1'b1;
    end else begin
      if (pw_ok) begin
        par_d  = pw_wdata;
        lock_d = 1'b0;
        oe_d   = 1'b1;
      end
      if (dx_ok) begin
        data_d = dx_wdata;
        oe_d   = 1'b1;
      end
    end
    dstb_d = rel_stb | dx_ok;
    pstb_d = rel_stb | pw_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      par_q  <= '1;
      oe_q   <= 1'b0;
      lock_q <= 1'b1;
      dstb_q <= 1'b0;
      pstb_q <= 1'b0;
    end else begin
      data_q <= data_d;
      par_q  <= par_d;
      oe_q   <= oe_d;
      lock_q <= lock_d;
      dstb_q <= dstb_d;
      pstb_q <= pstb_d;
    end
  end

  assign data_out = data_q;
  assign par_out  = par_q;
  assign oe       = oe_q;
  assign lock     = lock_q;
  assign data_stb = dstb_q;
  assign par_stb  = pstb_q;

endmodule

// File: rtl/slave_reset_seq.sv
module slave_reset_seq
  import slv_rst_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SW_INIT_MS  = 2,
  parameter int POR_INIT_MS = 30,
  parameter int DW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_in,
  input  logic          sw_rst_req,
  input  logic          ext_rst_req,
  input  logic          dx_req,
  input  logic [DW-1:0] dx_wdata,
  input  logic          pw_req,
  input  logic [DW-1:0] pw_wdata,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] par_out,
  output logic          par_oe,
  output logic          data_stb,
  output logic          par_stb,
  output logic          init_busy,
  output logic          dx_lock
);

  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int SHORT_CYC  = CYC_PER_MS * SW_INIT_MS;
  localparam int LONG_CYC   = CYC_PER_MS * POR_INIT_MS;
  localparam int CNT_W      = $clog2(LONG_CYC + 1);

  logic [2:0] src_sync;
  logic       rst_any;
  rst_kind_e  rst_kind;
  logic       rel_stb;
  logic       oe;

  slv_rst_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sw_rst_req, ext_rst_req, por_in}),
    .sync_out (src_sync)
  );

  assign rst_any  = |src_sync;
  assign rst_kind = pick_kind(src_sync);

  slv_rst_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_any (rst_any),
    .kind_in (rst_kind),
    .busy    (init_busy),
    .rel_stb (rel_stb)
  );

  slv_rst_outs #(.DW(DW)) u_outs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_any  (rst_any),
    .busy     (init_busy),
    .rel_stb  (rel_stb),
    .dx_req   (dx_req),
    .dx_wdata (dx_wdata),
    .pw_req   (pw_req),
    .pw_wdata (pw_wdata),
    .data_out (data_out),
    .par_out  (par_out),
    .oe       (oe),
    .lock     (dx_lock),
    .data_stb (data_stb),
    .par_stb  (par_stb)
  );

  assign data_oe = oe;
  assign par_oe  = oe;

endmodule

// File: rtl/slave_reset_seq_chk.sv
module slave_reset_seq_chk
  import slv_rst_pkg::*;
#(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_any,
  input rst_kind_e     rst_kind,
  input logic          dx_req,
  input logic          pw_req,
  input logic [DW-1:0] pw_wdata,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic [DW-1:0] par_out,
  input logic          par_oe,
  input logic          data_stb,
  input logic          par_stb,
  input logic          init_busy,
  input logic          dx_lock
);

  a_r1_preset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> (data_out == {DW{1'b1}}) && (par_out == {DW{1'b1}}));

  a_r2_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> !data_oe && !par_oe);

  a_r3_pair_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_any && $past(rst_any) && $past(rst_kind) != RK_POR) |=> data_stb && par_stb);

  a_r4_quiet_por: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_any && $past(rst_any) && $past(rst_kind) == RK_POR) |=> !data_stb && !par_stb);

  a_r5_lock_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> dx_lock && init_busy);

  a_r6_locked_dx: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_req && dx_lock && !rst_any) |=> $stable(data_out));

  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !rst_any && pw_req) |=> $stable(par_out) && $stable(dx_lock));

  a_r9_pwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_busy && !rst_any && pw_req) |=>
      par_stb && !dx_lock && data_oe && par_oe && (par_out == $past(pw_wdata)));

endmodule

bind slave_reset_seq slave_reset_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_any   (rst_any),
  .rst_kind  (rst_kind),
  .dx_req    (dx_req),
  .pw_req    (pw_req),
  .pw_wdata  (pw_wdata),
  .data_out  (data_out),
  .data_oe   (data_oe),
  .par_out   (par_out),
  .par_oe    (par_oe),
  .data_stb  (data_stb),
  .par_stb   (par_stb),
  .init_busy (init_busy),
  .dx_lock   (dx_lock)
);

// File: tb/slave_reset_seq_bench.sv
module slave_reset_seq_bench;

  localparam int CLK_HZ = 4000;
  localparam int DW     = 4;
  localparam int SHORT  = CLK_HZ / 1000 * 2;
  localparam int LONG   = CLK_HZ / 1000 * 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          por_in, sw_rst_req, ext_rst_req;
  logic          dx_req, pw_req;
  logic [DW-1:0] dx_wdata, pw_wdata;
  logic [DW-1:0] data_out, par_out;
  logic          data_oe, par_oe, data_stb, par_stb, init_busy, dx_lock;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int r_busy, r_both, r_single, r_after;
  bit r_state_ok;

  always #10 clk = ~clk;

  slave_reset_seq #(.CLK_HZ(CLK_HZ), .DW(DW)) u_slave_reset_seq (
    .clk(clk), .rst_n(rst_n), .por_in(por_in), .sw_rst_req(sw_rst_req),
    .ext_rst_req(ext_rst_req), .dx_req(dx_req), .dx_wdata(dx_wdata),
    .pw_req(pw_req), .pw_wdata(pw_wdata), .data_out(data_out),
    .data_oe(data_oe), .par_out(par_out), .par_oe(par_oe),
    .data_stb(data_stb), .par_stb(par_stb), .init_busy(init_busy),
    .dx_lock(dx_lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int kind, input logic v);
    if (kind == 0) por_in = v;
    else if (kind == 1) sw_rst_req = v;
    else ext_rst_req = v;
  endtask

  // kind: 0 power-on, 1 software, 2 external; called right after a negedge
  task automatic run_reset(input int kind, input int p, input bit inject);
    bit seen;
    seen = 1'b0;
    r_busy = 0; r_both = 0; r_single = 0; r_after = 0; r_state_ok = 1'b1;
    set_src(kind, 1'b1);
    for (int i = 1; i < 3000; i++) begin
      @(negedge clk);
      if (i == p) set_src(kind, 1'b0);
      pw_req = 1'b0;
      if (init_busy) begin
        seen = 1'b1;
        r_busy++;
      end
      if (data_stb && par_stb) begin
        r_both++;
        if (data_out != 4'hF || par_out != 4'hF || data_oe || par_oe || !dx_lock)
          r_state_ok = 1'b0;
        if (inject) begin
          pw_req   = 1'b1;
          pw_wdata = 4'h3;
        end
      end else if (data_stb || par_stb) begin
        r_single++;
      end
      if (r_both > 0 && init_busy) r_after++;
      if (seen && !init_busy) break;
    end
    pw_req = 1'b0;
  endtask

  task automatic pw_write(input logic [DW-1:0] v);
    pw_req = 1'b1; pw_wdata = v;
    @(negedge clk);
    pw_req = 1'b0;
  endtask

  task automatic dx_write(input logic [DW-1:0] v);
    dx_req = 1'b1; dx_wdata = v;
    @(negedge clk);
    dx_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit stb_seen;
    rst_n = 1'b0; por_in = 1'b0; sw_rst_req = 1'b0; ext_rst_req = 1'b0;
    dx_req = 1'b0; pw_req = 1'b0; dx_wdata = '0; pw_wdata = '0;
    repeat (3) @(negedge clk);
    chk(data_out == 4'hF && par_out == 4'hF, "R1 reset preset", int'(data_out), 15);
    chk(!data_oe && !par_oe, "R2 reset hi-z", int'(data_oe | par_oe), 0);
    chk(dx_lock && init_busy && !data_stb && !par_stb, "R5 reset lock/busy", int'(dx_lock), 1);
    rst_n = 1'b1;

    // R4 R7: power-on window after chip reset
    cnt = 0; stb_seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (data_stb || par_stb) stb_seen = 1'b1;
      if (!init_busy) break;
      cnt++;
    end
    chk(cnt == LONG - 1, "R7 power-on window", cnt, LONG - 1);
    chk(!stb_seen, "R4 no strobe after power-on", int'(stb_seen), 0);

    // R6: data exchange before any parameter write
    dx_write(4'h5);
    chk(data_out == 4'hF && !data_stb, "R6 locked data exchange", int'(data_out), 15);
    // R6: same-cycle write and exchange while locked
    dx_req = 1'b1; dx_wdata = 4'h9; pw_req = 1'b1; pw_wdata = 4'h6;
    @(negedge clk);
    dx_req = 1'b0; pw_req = 1'b0;
    chk(data_out == 4'hF && !data_stb, "R6 same-cycle exchange ignored", int'(data_out), 15);
    chk(par_out == 4'h6 && !dx_lock, "R9 same-cycle write", int'(par_out), 6);

    // R9 parameter sweep
    for (int v = 0; v < 16; v++) begin
      pw_write(v[DW-1:0]);
      chk(par_out == v[DW-1:0] && par_stb && !data_stb && par_oe && data_oe && !dx_lock,
          "R9 parameter write", int'(par_out), v);
    end
    // R10 data sweep
    for (int v = 15; v >= 0; v--) begin
      dx_write(v[DW-1:0]);
      chk(data_out == v[DW-1:0] && data_stb && !par_stb && data_oe && par_oe,
          "R10 data exchange", int'(data_out), v);
    end

    // software reset, P=3
    run_reset(1, 3, 1'b0);
    chk(r_busy == 3 + SHORT - 1, "R7 software window", r_busy, 3 + SHORT - 1);
    chk(r_after == SHORT - 1, "R7 window after strobe", r_after, SHORT - 1);
    chk(r_both == 1 && r_single == 0, "R3 software paired strobe", r_both, 1);
    chk(r_state_ok, "R1 R2 R5 state at release", int'(r_state_ok), 1);
    dx_write(4'hA);
    chk(data_out == 4'hF && !data_stb, "R6 lock after software reset", int'(data_out), 15);
    pw_write(4'h2);

    // external reset, P=1
    run_reset(2, 1, 1'b0);
    chk(r_busy == SHORT, "R7 external window", r_busy, SHORT);
    chk(r_both == 1 && r_single == 0, "R3 external paired strobe", r_both, 1);
    pw_write(4'h2);

    // power-on pulse, P=4
    run_reset(0, 4, 1'b0);
    chk(r_busy == 4 + LONG - 1, "R7 power-on pulse window", r_busy, 4 + LONG - 1);
    chk(r_both == 0 && r_single == 0, "R4 power-on silent", r_both + r_single, 0);
    pw_write(4'h2);

    // R8: parameter write during initialization
    run_reset(1, 2, 1'b1);
    chk(r_both == 1 && r_single == 0, "R8 no extra strobe while busy", r_single, 0);
    chk(par_out == 4'hF && dx_lock, "R8 write ignored while busy", int'(par_out), 15);
    pw_write(4'h2);

    // R11: power-on then software reset during init
    por_in = 1'b1; repeat (2) @(negedge clk); por_in = 1'b0;
    repeat (10) @(negedge clk);
    run_reset(1, 2, 1'b0);
    chk(r_after == SHORT - 1, "R11 restart with software window", r_after, SHORT - 1);
    chk(r_both == 1, "R11 strobe after software restart", r_both, 1);
    pw_write(4'h2);

    // R11: software then power-on during init
    sw_rst_req = 1'b1; repeat (2) @(negedge clk); sw_rst_req = 1'b0;
    repeat (4) @(negedge clk);
    run_reset(0, 2, 1'b0);
    chk(r_busy == 2 + LONG + 1, "R11 restart with power-on window", r_busy, 2 + LONG + 1);
    chk(r_both == 0 && r_single == 0, "R11 no strobe after power-on restart", r_both, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule